// File: doc/BRIEF.md
# Translation Entry Permission Checker

This block sits behind a translation lookup and decides whether one memory access may go ahead, using the access-control bits of the entry that matched. Each request names its kind (instruction fetch, load or store) and the privilege level it runs at. The block picks the single permission bit that governs that pairing and either grants the access or raises a fault. An instruction fetch that is refused raises an instruction-side fault. A refused load or store raises a data-side fault. Both carry a cause code.

Faults are registered and stay up until software pulses a clear input. While a fault is outstanding the block stops taking requests. The checked entry's permission bits and its referenced flag live in the block. They change only through an explicit update port, and an access never changes them, whatever its outcome. Reference and change tracking is left entirely to software: an entry is written with its permissions off, and software learns of first use from the fault it takes.

Top module: `acc_perm_checker`

## Requirements
- R1: After reset, `acc_allow`, `flt_istor` and `flt_dstor` are 0, `flt_cause` is 0, `req_ready` is 1, and `ent_perm` and `ent_ref` are 0.
- R2: `ent_perm` bit positions are [0] user execute, [1] supervisor execute, [2] user read, [3] supervisor read, [4] user write, [5] supervisor write. A user request (`req_sup`=0) consults only bits 0, 2 and 4. A supervisor request consults only bits 1, 3 and 5.
- R3: An accepted request whose governing bit is set drives `acc_allow` high for exactly the one cycle after the accepting edge, with no fault raised.
- R4: A refused fetch (`req_kind`=0) sets `flt_istor`=1, `flt_dstor`=0 and `flt_cause`=1 from the edge after acceptance, and `acc_allow` stays 0.
- R5: A refused load (`req_kind`=1) sets `flt_dstor`=1 and `flt_cause`=2. A refused store (`req_kind`=2) sets `flt_dstor`=1 and `flt_cause`=3. In both cases `flt_istor`=0 and `acc_allow`=0.
- R6: A raised fault and its cause hold unchanged until `flt_clear` is sampled high. All fault outputs are 0 after that edge.
- R7: While a fault is held, `req_ready` is 0 and requests are ignored: no grant, and the held fault and cause are unchanged.
- R8: Accesses, granted or refused, never change `ent_perm` or `ent_ref`.
- R9: When `upd_valid` is sampled high, `ent_perm`/`ent_ref` take `upd_perm`/`upd_ref` at that edge. A request accepted on the same edge is judged against the old contents, and later requests are judged against the new ones.
- R10: `req_kind`=3 is not an access. It produces neither a grant nor a fault.
- R11: An entry with its read bit set and its write bit clear grants loads and refuses stores at the same privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 not an access |
| req_sup | input | 1 | 1 = supervisor, 0 = user |
| req_ready | output | 1 | Request can be taken (no fault held) |
| upd_valid | input | 1 | Rewrite the entry |
| upd_perm | input | 6 | New permission bits |
| upd_ref | input | 1 | New referenced flag |
| flt_clear | input | 1 | Drop the held fault |
| acc_allow | output | 1 | Access granted (one-cycle pulse) |
| flt_istor | output | 1 | Instruction-side fault held |
| flt_dstor | output | 1 | Data-side fault held |
| flt_cause | output | 2 | 0 none, 1 execute, 2 read, 3 write refused |
| ent_perm | output | 6 | Current permission bits of the entry |
| ent_ref | output | 1 | Current referenced flag of the entry |

## Verification
A single permission bit is walked through all six positions while every kind and privilege pair is tried against it. A design that swapped the user and supervisor columns, or read the wrong bit for a kind, grants where it must refuse, or refuses where it must grant. An update issued on the same edge as a request shows whether the design judges the request against the old entry or wrongly forwards the new bits. A fault held while requests keep arriving exposes a design that lets those requests overwrite the cause, or grant through the stall. The referenced flag and the permission bits are read back after both granted and refused accesses, which catches any hardware that marks an entry as used.

// File: rtl/acc_perm_pkg.sv
package acc_perm_pkg;
  localparam int KIND_W  = 2;
  localparam int PERM_W  = 6;
  localparam int CAUSE_W = 2;
  localparam int SLOT_W  = $clog2(PERM_W + 2);

  typedef enum logic [KIND_W-1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_NONE  = 2'd3
  } acc_kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_EXEC  = 2'd1,
    CAUSE_READ  = 2'd2,
    CAUSE_WRITE = 2'd3
  } acc_cause_e;

  // Position of the governing bit: two bits per kind, supervisor is the odd one.
  function automatic logic [SLOT_W-1:0] perm_slot(logic [KIND_W-1:0] kind, logic sup);
    return SLOT_W'({kind, sup});
  endfunction

  function automatic acc_cause_e deny_cause(logic [KIND_W-1:0] kind);
    case (kind)
      KIND_FETCH: return CAUSE_EXEC;
      KIND_LOAD:  return CAUSE_READ;
      KIND_STORE: return CAUSE_WRITE;
      default:    return CAUSE_NONE;
    endcase
  endfunction

  function automatic logic is_access(logic [KIND_W-1:0] kind);
    return kind != KIND_NONE;
  endfunction
endpackage

// File: rtl/acc_entry_store.sv
module acc_entry_store #(
  parameter int                PERM_W   = acc_perm_pkg::PERM_W,
  parameter logic [PERM_W-1:0] RST_PERM = '0,
  parameter logic              RST_REF  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [PERM_W-1:0] upd_perm,
  input  logic              upd_ref,
  output logic [PERM_W-1:0] perm_q,
  output logic              ref_q
);
  // Only the update port writes the entry; accesses have no path here.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perm_q <= RST_PERM;
      ref_q  <= RST_REF;
    end else if (upd_valid) begin
      perm_q <= upd_perm;
      ref_q  <= upd_ref;
    end
  end
endmodule

// File: rtl/acc_perm_select.sv
module acc_perm_select #(
  parameter int PERM_W  = acc_perm_pkg::PERM_W,
  parameter int KIND_W  = acc_perm_pkg::KIND_W,
  parameter int CAUSE_W = acc_perm_pkg::CAUSE_W
) (
  input  logic [PERM_W-1:0]  perm,
  input  logic [KIND_W-1:0]  kind,
  input  logic               sup,
  output logic               grant,
  output logic               kind_ok,
  output logic [CAUSE_W-1:0] cause
);
  import acc_perm_pkg::*;
  localparam int SW = acc_perm_pkg::SLOT_W;

  logic [SW-1:0]     slot;
  logic [PERM_W-1:0] hit;

  assign slot = perm_slot(kind, sup);

  // One match line per permission bit; at most one can be selected.
  for (genvar i = 0; i < PERM_W; i++) begin : g_hit
    assign hit[i] = perm[i] && (slot == SW'(i));
  end

  assign kind_ok = is_access(kind);
  assign grant   = kind_ok && (|hit);
  assign cause   = CAUSE_W'(deny_cause(kind));
endmodule

// File: rtl/acc_fault_hold.sv
module acc_fault_hold #(
  parameter int CAUSE_W = acc_perm_pkg::CAUSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               grant,
  input  logic               is_fetch,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic               clear,
  output logic               allow_q,
  output logic               istor_q,
  output logic               dstor_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      allow_q <= 1'b0;
      istor_q <= 1'b0;
      dstor_q <= 1'b0;
      cause_q <= '0;
    end else begin
      allow_q <= accept && grant;
      if (clear) begin
        istor_q <= 1'b0;
        dstor_q <= 1'b0;
        cause_q <= '0;
      end else if (accept && !grant) begin
        istor_q <= is_fetch;
        dstor_q <= !is_fetch;
        cause_q <= cause_in;
      end
    end
  end

  assign pending = istor_q || dstor_q;
endmodule

// File: rtl/acc_perm_checker.sv
module acc_perm_checker #(
  parameter int                PERM_W   = acc_perm_pkg::PERM_W,
  parameter int                KIND_W   = acc_perm_pkg::KIND_W,
  parameter int                CAUSE_W  = acc_perm_pkg::CAUSE_W,
  parameter logic [PERM_W-1:0] RST_PERM = '0,
  parameter logic              RST_REF  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic               req_sup,
  output logic               req_ready,
  input  logic               upd_valid,
  input  logic [PERM_W-1:0]  upd_perm,
  input  logic               upd_ref,
  input  logic               flt_clear,
  output logic               acc_allow,
  output logic               flt_istor,
  output logic               flt_dstor,
  output logic [CAUSE_W-1:0] flt_cause,
  output logic [PERM_W-1:0]  ent_perm,
  output logic               ent_ref
);
  import acc_perm_pkg::*;

  // Named internal events, visible to the bound checker.
  logic               chk_accept;
  logic               chk_grant;
  logic               chk_kind_ok;
  logic               chk_pending;
  logic [CAUSE_W-1:0] chk_cause;

  acc_entry_store #(
    .PERM_W  (PERM_W),
    .RST_PERM(RST_PERM),
    .RST_REF (RST_REF)
  ) u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_valid(upd_valid),
    .upd_perm (upd_perm),
    .upd_ref  (upd_ref),
    .perm_q   (ent_perm),
    .ref_q    (ent_ref)
  );

  acc_perm_select #(
    .PERM_W (PERM_W),
    .KIND_W (KIND_W),
    .CAUSE_W(CAUSE_W)
  ) u_select (
    .perm   (ent_perm),
    .kind   (req_kind),
    .sup    (req_sup),
    .grant  (chk_grant),
    .kind_ok(chk_kind_ok),
    .cause  (chk_cause)
  );

  assign req_ready  = !chk_pending;
  assign chk_accept = req_valid && req_ready && chk_kind_ok;

  acc_fault_hold #(
    .CAUSE_W(CAUSE_W)
  ) u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (chk_accept),
    .grant   (chk_grant),
    .is_fetch(req_kind == KIND_FETCH),
    .cause_in(chk_cause),
    .clear   (flt_clear),
    .allow_q (acc_allow),
    .istor_q (flt_istor),
    .dstor_q (flt_dstor),
    .cause_q (flt_cause),
    .pending (chk_pending)
  );
endmodule

// File: rtl/acc_perm_checker_sva.sv
module acc_perm_checker_sva #(
  parameter int PERM_W  = acc_perm_pkg::PERM_W,
  parameter int CAUSE_W = acc_perm_pkg::CAUSE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               acc_allow,
  input logic               flt_istor,
  input logic               flt_dstor,
  input logic [CAUSE_W-1:0] flt_cause,
  input logic               flt_clear,
  input logic               upd_valid,
  input logic [PERM_W-1:0]  upd_perm,
  input logic               upd_ref,
  input logic [PERM_W-1:0]  ent_perm,
  input logic               ent_ref,
  input logic               chk_accept,
  input logic               chk_grant
);
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_accept && chk_grant) |=> (acc_allow && !flt_istor && !flt_dstor)); // R3
  AST_ALLOW_ONLY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_accept |=> !acc_allow); // R3
  AST_ISIDE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_istor |-> (!flt_dstor && flt_cause == 2'd1)); // R4
  AST_DSIDE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_dstor |-> (flt_cause == 2'd2 || flt_cause == 2'd3)); // R5
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((flt_istor || flt_dstor) && !flt_clear) |=>
      ($stable(flt_istor) && $stable(flt_dstor) && $stable(flt_cause))); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clear |=> (!flt_istor && !flt_dstor && flt_cause == '0)); // R6
  AST_STALL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !acc_allow); // R7
  AST_ENTRY_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(ent_perm) && $stable(ent_ref))); // R8
  AST_UPDATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ent_perm == $past(upd_perm) && ent_ref == $past(upd_ref))); // R9
endmodule

bind acc_perm_checker acc_perm_checker_sva #(
  .PERM_W (PERM_W),
  .CAUSE_W(CAUSE_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .acc_allow (acc_allow),
  .flt_istor (flt_istor),
  .flt_dstor (flt_dstor),
  .flt_cause (flt_cause),
  .flt_clear (flt_clear),
  .upd_valid (upd_valid),
  .upd_perm  (upd_perm),
  .upd_ref   (upd_ref),
  .ent_perm  (ent_perm),
  .ent_ref   (ent_ref),
  .chk_accept(chk_accept),
  .chk_grant (chk_grant)
);

// File: tb/acc_perm_checker_bench.sv
`timescale 1ns/1ps
module acc_perm_checker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic       req_sup = 1'b0;
  logic       req_ready;
  logic       upd_valid = 1'b0;
  logic [5:0] upd_perm = 6'd0;
  logic       upd_ref = 1'b0;
  logic       flt_clear = 1'b0;
  logic       acc_allow, flt_istor, flt_dstor;
  logic [1:0] flt_cause;
  logic [5:0] ent_perm;
  logic       ent_ref;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_perm_checker u_acc_perm_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_sup(req_sup), .req_ready(req_ready), .upd_valid(upd_valid),
    .upd_perm(upd_perm), .upd_ref(upd_ref), .flt_clear(flt_clear),
    .acc_allow(acc_allow), .flt_istor(flt_istor), .flt_dstor(flt_dstor),
    .flt_cause(flt_cause), .ent_perm(ent_perm), .ent_ref(ent_ref)
  );

  // Bench model of the requirements: the governing bit per kind and privilege.
  function automatic bit model_allow(logic [5:0] p, logic [1:0] k, logic s);
    case (k)
      2'd0: return s ? p[1] : p[0];
      2'd1: return s ? p[3] : p[2];
      2'd2: return s ? p[5] : p[4];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] model_cause(logic [1:0] k);
    if (k == 2'd0) return 2'd1;
    if (k == 2'd1) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end one time unit after a rising edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_update(logic [5:0] p, logic r);
    upd_valid = 1'b1; upd_perm = p; upd_ref = r;
    step();
    upd_valid = 1'b0;
    chk("R9 entry perm after update", 8'(ent_perm), 8'(p));
    chk("R9 entry ref after update", 8'(ent_ref), 8'(r));
  endtask

  task automatic do_clear();
    flt_clear = 1'b1;
    step();
    flt_clear = 1'b0;
    chk("R6 istor cleared", 8'(flt_istor), 8'd0);
    chk("R6 dstor cleared", 8'(flt_dstor), 8'd0);
    chk("R6 cause cleared", 8'(flt_cause), 8'd0);
    chk("R7 ready after clear", 8'(req_ready), 8'd1);
  endtask

  // One access judged against entry contents p; clears any fault it raises.
  task automatic do_access(logic [5:0] p, logic [1:0] k, logic s, string tag);
    bit ok;
    ok = model_allow(p, k, s);
    req_valid = 1'b1; req_kind = k; req_sup = s;
    step();
    req_valid = 1'b0;
    chk({tag, " allow"}, 8'(acc_allow), 8'(ok));
    if (ok) begin
      chk({tag, " R3 no fault"}, 8'(flt_istor | flt_dstor), 8'd0);
      step();
      chk({tag, " R3 allow one cycle"}, 8'(acc_allow), 8'd0);
    end else begin
      if (k == 2'd0) tag = {tag, " R4"}; else tag = {tag, " R5"};
      chk({tag, " istor"}, 8'(flt_istor), 8'(k == 2'd0));
      chk({tag, " dstor"}, 8'(flt_dstor), 8'(k != 2'd0));
      chk({tag, " cause"}, 8'(flt_cause), 8'(model_cause(k)));
      do_clear();
    end
    chk({tag, " R8 perm kept"}, 8'(ent_perm), 8'(p));
  endtask

  task automatic t_reset();
    chk("R1 allow", 8'(acc_allow), 8'd0);
    chk("R1 istor", 8'(flt_istor), 8'd0);
    chk("R1 dstor", 8'(flt_dstor), 8'd0);
    chk("R1 cause", 8'(flt_cause), 8'd0);
    chk("R1 ready", 8'(req_ready), 8'd1);
    chk("R1 perm", 8'(ent_perm), 8'd0);
    chk("R1 ref", 8'(ent_ref), 8'd0);
  endtask

  task automatic t_all_open();
    do_update(6'h3F, 1'b0);
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 2; s++)
        do_access(6'h3F, 2'(k), 1'(s), "R3 open entry");
  endtask

  task automatic t_walk_bit();
    for (int b = 0; b < 6; b++) begin
      do_update(6'(1 << b), 1'b0);
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 2; s++)
          do_access(6'(1 << b), 2'(k), 1'(s), "R2 single bit");
    end
  endtask

  task automatic t_read_only();
    do_update(6'b001100, 1'b0);
    do_access(6'b001100, 2'd1, 1'b0, "R11 user load");
    do_access(6'b001100, 2'd2, 1'b0, "R11 user store");
    do_access(6'b001100, 2'd1, 1'b1, "R11 sup load");
    do_access(6'b001100, 2'd2, 1'b1, "R11 sup store");
  endtask

  task automatic t_stall();
    do_update(6'b000100, 1'b0);
    req_valid = 1'b1; req_kind = 2'd2; req_sup = 1'b0;
    step();
    chk("R5 store fault cause", 8'(flt_cause), 8'd3);
    req_kind = 2'd1;  // a load that the entry would grant
    for (int i = 0; i < 3; i++) begin
      chk("R7 ready low", 8'(req_ready), 8'd0);
      step();
      chk("R7 no grant while held", 8'(acc_allow), 8'd0);
      chk("R6 dstor held", 8'(flt_dstor), 8'd1);
      chk("R6 cause held", 8'(flt_cause), 8'd3);
    end
    req_valid = 1'b0;
    do_clear();
    do_access(6'b000100, 2'd1, 1'b0, "R7 load after clear");
  endtask

  task automatic t_same_cycle_update();
    do_update(6'h00, 1'b0);
    req_valid = 1'b1; req_kind = 2'd1; req_sup = 1'b0;
    upd_valid = 1'b1; upd_perm = 6'h3F; upd_ref = 1'b0;
    step();
    req_valid = 1'b0; upd_valid = 1'b0;
    chk("R9 old entry judged: allow", 8'(acc_allow), 8'd0);
    chk("R9 old entry judged: cause", 8'(flt_cause), 8'd2);
    chk("R9 new entry stored", 8'(ent_perm), 8'h3F);
    do_clear();
    do_access(6'h3F, 2'd1, 1'b0, "R9 next access uses new entry");
  endtask

  task automatic t_no_access_kind();
    req_valid = 1'b1; req_kind = 2'd3; req_sup = 1'b0;
    step();
    req_valid = 1'b0;
    chk("R10 no grant", 8'(acc_allow), 8'd0);
    chk("R10 no fault", 8'(flt_istor | flt_dstor), 8'd0);
    chk("R10 ready", 8'(req_ready), 8'd1);
  endtask

  task automatic t_ref_untouched();
    do_update(6'b010101, 1'b1);
    do_access(6'b010101, 2'd0, 1'b0, "R8 granted fetch");
    do_access(6'b010101, 2'd0, 1'b1, "R8 refused fetch");
    do_access(6'b010101, 2'd2, 1'b0, "R8 granted store");
    chk("R8 ref stays set", 8'(ent_ref), 8'd1);
    do_update(6'h3F, 1'b0);
    do_access(6'h3F, 2'd1, 1'b1, "R8 granted load");
    do_access(6'h3F, 2'd2, 1'b1, "R8 granted store");
    chk("R8 ref stays clear", 8'(ent_ref), 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_all_open();
    t_walk_bit();
    t_read_only();
    t_stall();
    t_same_cycle_update();
    t_no_access_kind();
    t_ref_untouched();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule